// File: doc/BRIEF.md
# Command-Phased Host Register Interface

This block is the slave side of a 16-bit asynchronous microprocessor bus. Its pins are an active-low chip select, one address line, and active-low read and write strobes. The data bus is split into an input half and an output half, plus an output-enable. An access always opens with a command phase, which is a write with the address line high. That write names a register and the direction of the transfer. Data phases follow with the address line low, and each one moves one 16-bit word to or from the named register.

Behind the bus sits a small register file. It holds two 16-bit general registers, two 32-bit wide registers and a read-only buffer status word. A separate streaming port moves consecutive words into and out of a 16-word buffer memory. Bus pins are synchronised into the system clock. Each strobe acts once, on its rising edge.

A phase controller sequences the words. It has five states: IDLE, WORD_LO, WORD_HI, DONE and STREAM. Reset enters IDLE. From any state, a command enters STREAM for the buffer code and WORD_LO for every other code. From WORD_LO, a data phase leads to WORD_HI for a wide register and to DONE otherwise. From WORD_HI, a data phase leads to DONE. A data phase leaves IDLE, DONE and STREAM in place.

Top module: `hreg_port`

## Requirements
- R1: A command phase is a write strobe while chip select is low and the address line is high. In the command word, bit 7 = 1 marks a write and bit 7 = 0 marks a read. Bits 6:0 are the register code, and bits 15:8 are ignored. Register codes: 0x01 and 0x02 are 16-bit registers, 0x10 and 0x11 are 32-bit registers, 0x20 is buffer status, and 0x30 is the buffer port. During a data read (chip select low, read strobe low, address low), the output-enable is high.
- R2: A 16-bit register is written or read with one data phase after its command.
- R3: A 32-bit register is moved in two data phases. The first carries bits 15:0 and the second carries bits 31:16.
- R4: A 32-bit register changes only when its upper word is written. A lower word alone leaves the register at its old value.
- R5: Once a register's width is used up, further data phases are ignored on write and return zero on read.
- R6: A new command restarts word sequencing, even after an unfinished 32-bit access.
- R7: Data phases to the buffer port move consecutive words. Every command to the buffer port resets the word pointer to word 0.
- R8: A write after the 16th buffer word is discarded and sets bit 0 of the status register (code 0x20). That bit is sticky and cannot be written. Reads past the end of the buffer return zero.
- R9: A code not listed in R1 reads as zero, and writes to it are discarded.
- R10: A data write under a read command is ignored. A data read under a write command returns zero.
- R11: A strobe counts as exactly one phase however long it is held. A strobe while chip select is high is ignored.
- R12: After reset, every register reads zero, the controller is in IDLE, and the output-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| a0 | input | 1 | Address line: 1 = command, 0 = data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| d_in | input | 16 | Data bus sampled on writes |
| d_out | output | 16 | Data bus driven on reads |
| d_oe | output | 1 | High while d_out should drive the bus |

## Verification
On every cycle, the assertions check several properties. A wide register changes only on an upper-word write. The overflow flag, once set, stays set. The buffer pointer stays within bounds. A command always lands in WORD_LO or STREAM. DONE holds until the next command. IDLE drives zero, and each synchronised strobe yields a one-cycle event. The bench scenarios are needed to show which values actually reach the bus. That covers lower-then-upper word order, command bits that are ignored, direction mismatches, unknown codes, long strobes, strobes while deselected, pointer restart and the data seen past the end of the buffer.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WORD_LO,
        ST_WORD_HI,
        ST_DONE,
        ST_STREAM
    } phase_e;

    localparam logic [6:0] CODE_GP_A     = 7'h01;
    localparam logic [6:0] CODE_GP_B     = 7'h02;
    localparam logic [6:0] CODE_WIDE_A   = 7'h10;
    localparam logic [6:0] CODE_WIDE_B   = 7'h11;
    localparam logic [6:0] CODE_BUF_STAT = 7'h20;
    localparam logic [6:0] CODE_BUF_PORT = 7'h30;

    typedef struct packed {
        logic        cs_n;
        logic        a0;
        logic        rd_n;
        logic        wr_n;
        logic [15:0] data;
    } pin_s;

    localparam pin_s PINS_IDLE = '{cs_n: 1'b1, a0: 1'b0, rd_n: 1'b1, wr_n: 1'b1, data: 16'h0000};

    function automatic logic code_is_wide(input logic [6:0] code);
        return (code == CODE_WIDE_A) || (code == CODE_WIDE_B);
    endfunction

endpackage

// File: rtl/hreg_bus_sync.sv
module hreg_bus_sync
    import hreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  pin_s        pins_i,
    output logic        cmd_evt,
    output logic        wr_evt,
    output logic        rd_evt,
    output logic [15:0] data_o
);

    pin_s chain [SYNC_STAGES];
    pin_s prev_q;
    pin_s cur;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[i] <= PINS_IDLE;
            end else if (i == 0) begin
                chain[i] <= pins_i;
            end else begin
                chain[i] <= chain[(i == 0) ? 0 : i - 1];
            end
        end
    end

    assign cur = chain[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= PINS_IDLE;
        end else begin
            prev_q <= cur;
        end
    end

    logic wr_rise;
    logic rd_rise;

    // act on deassertion; qualifiers come from the sample taken while the strobe was low
    assign wr_rise = cur.wr_n & ~prev_q.wr_n & ~prev_q.cs_n;
    assign rd_rise = cur.rd_n & ~prev_q.rd_n & ~prev_q.cs_n;

    assign cmd_evt = wr_rise & prev_q.a0;
    assign wr_evt  = wr_rise & ~prev_q.a0;
    assign rd_evt  = rd_rise & ~prev_q.a0;
    assign data_o  = prev_q.data;

endmodule

// File: rtl/hreg_phase_fsm.sv
module hreg_phase_fsm
    import hreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_evt,
    input  logic        wr_evt,
    input  logic        rd_evt,
    input  logic [15:0] cmd_word,
    output phase_e      state_o,
    output logic [6:0]  code_o,
    output logic        dir_wr_o,
    output logic        write16_o,
    output logic        stage_lo_o,
    output logic        write_hi_o,
    output logic        snap_o,
    output logic        buf_push_o,
    output logic        buf_pop_o,
    output logic        buf_restart_o
);

    phase_e     st_q, st_d;
    logic [6:0] code_q;
    logic       dir_wr_q;
    logic       wide;
    logic       data_evt;

    assign wide     = code_is_wide(code_q);
    assign data_evt = wr_evt | rd_evt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            code_q   <= '0;
            dir_wr_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (cmd_evt) begin
                code_q   <= cmd_word[6:0];
                dir_wr_q <= cmd_word[7];
            end
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        if (cmd_evt) begin
            st_d = (cmd_word[6:0] == CODE_BUF_PORT) ? ST_STREAM : ST_WORD_LO;
        end else if (data_evt) begin
            unique case (st_q)
                ST_WORD_LO: st_d = wide ? ST_WORD_HI : ST_DONE;
                ST_WORD_HI: st_d = ST_DONE;
                default:    st_d = st_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        write16_o  = 1'b0;
        stage_lo_o = 1'b0;
        write_hi_o = 1'b0;
        snap_o     = 1'b0;
        buf_push_o = 1'b0;
        buf_pop_o  = 1'b0;
        unique case (st_q)
            ST_WORD_LO: begin
                if (wide) begin
                    stage_lo_o = wr_evt & dir_wr_q;
                    snap_o     = rd_evt & ~dir_wr_q;
                end else begin
                    write16_o  = wr_evt & dir_wr_q;
                end
            end
            ST_WORD_HI: write_hi_o = wr_evt & dir_wr_q;
            ST_STREAM: begin
                buf_push_o = wr_evt & dir_wr_q;
                buf_pop_o  = rd_evt & ~dir_wr_q;
            end
            default: ;
        endcase
    end

    assign buf_restart_o = cmd_evt & (cmd_word[6:0] == CODE_BUF_PORT);
    assign state_o       = st_q;
    assign code_o        = code_q;
    assign dir_wr_o      = dir_wr_q;

endmodule

// File: rtl/hreg_buf_store.sv
module hreg_buf_store #(
    parameter int DEPTH = 16,
    parameter int WORD_W = 16,
    localparam int PTR_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              push,
    input  logic              pop,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              ovf_o
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  ptr_q;
    logic              ovf_q;
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    assign in_range = ptr_q < LAST;
    assign idx      = ptr_q[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            ovf_q <= 1'b0;
        end else if (restart) begin
            ptr_q <= '0;
        end else if (push) begin
            if (in_range) begin
                ptr_q <= ptr_q + 1'b1;
            end else begin
                ovf_q <= 1'b1;
            end
        end else if (pop && in_range) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && in_range && !restart) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = in_range ? mem[idx] : '0;
    assign ptr_o = ptr_q;
    assign ovf_o = ovf_q;

endmodule

// File: rtl/hreg_regfile.sv
module hreg_regfile
    import hreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  phase_e      state,
    input  logic [6:0]  code,
    input  logic        dir_wr,
    input  logic [15:0] wdata,
    input  logic        write16,
    input  logic        stage_lo,
    input  logic        write_hi,
    input  logic        snap,
    input  logic        buf_ovf,
    input  logic [15:0] buf_rdata,
    output logic [15:0] rd_word,
    output logic [31:0] wide_a_o,
    output logic [31:0] wide_b_o
);

    logic [15:0] gp_a_q, gp_b_q;
    logic [31:0] wide_a_q, wide_b_q;
    logic [15:0] stage_q;
    logic [15:0] snap_hi_q;
    logic [15:0] low_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gp_a_q    <= '0;
            gp_b_q    <= '0;
            wide_a_q  <= '0;
            wide_b_q  <= '0;
            stage_q   <= '0;
            snap_hi_q <= '0;
        end else begin
            if (write16) begin
                if (code == CODE_GP_A) gp_a_q <= wdata;
                if (code == CODE_GP_B) gp_b_q <= wdata;
            end
            if (stage_lo) begin
                stage_q <= wdata;
            end
            if (write_hi) begin
                if (code == CODE_WIDE_A) wide_a_q <= {wdata, stage_q};
                if (code == CODE_WIDE_B) wide_b_q <= {wdata, stage_q};
            end
            if (snap) begin
                snap_hi_q <= (code == CODE_WIDE_A) ? wide_a_q[31:16] :
                             (code == CODE_WIDE_B) ? wide_b_q[31:16] : 16'h0000;
            end
        end
    end

    always_comb begin
        unique case (code)
            CODE_GP_A:     low_word = gp_a_q;
            CODE_GP_B:     low_word = gp_b_q;
            CODE_WIDE_A:   low_word = wide_a_q[15:0];
            CODE_WIDE_B:   low_word = wide_b_q[15:0];
            CODE_BUF_STAT: low_word = {15'b0, buf_ovf};
            default:       low_word = 16'h0000;
        endcase
    end

    always_comb begin
        rd_word = 16'h0000;
        if (!dir_wr) begin
            unique case (state)
                ST_WORD_LO: rd_word = low_word;
                ST_WORD_HI: rd_word = snap_hi_q;
                ST_STREAM:  rd_word = buf_rdata;
                default:    rd_word = 16'h0000;
            endcase
        end
    end

    assign wide_a_o = wide_a_q;
    assign wide_b_o = wide_b_q;

endmodule

// File: rtl/hreg_port.sv
module hreg_port
    import hreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BUF_DEPTH   = 16,
    localparam int PTR_W      = $clog2(BUF_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        a0,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [15:0] d_in,
    output logic [15:0] d_out,
    output logic        d_oe
);

    pin_s        pins;
    logic        cmd_evt, wr_evt, rd_evt;
    logic [15:0] bus_word;
    phase_e      st;
    logic [6:0]  code;
    logic        dir_wr;
    logic        write16, stage_lo, write_hi, snap;
    logic        buf_push, buf_pop, buf_restart;
    logic [15:0] buf_rdata;
    logic [PTR_W-1:0] buf_ptr;
    logic        buf_ovf;
    logic [15:0] rd_word;
    logic [31:0] wide_a, wide_b;

    assign pins = '{cs_n: cs_n, a0: a0, rd_n: rd_n, wr_n: wr_n, data: d_in};

    hreg_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_i  (pins),
        .cmd_evt (cmd_evt),
        .wr_evt  (wr_evt),
        .rd_evt  (rd_evt),
        .data_o  (bus_word)
    );

    hreg_phase_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_evt       (cmd_evt),
        .wr_evt        (wr_evt),
        .rd_evt        (rd_evt),
        .cmd_word      (bus_word),
        .state_o       (st),
        .code_o        (code),
        .dir_wr_o      (dir_wr),
        .write16_o     (write16),
        .stage_lo_o    (stage_lo),
        .write_hi_o    (write_hi),
        .snap_o        (snap),
        .buf_push_o    (buf_push),
        .buf_pop_o     (buf_pop),
        .buf_restart_o (buf_restart)
    );

    hreg_buf_store #(.DEPTH(BUF_DEPTH), .WORD_W(16)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (buf_restart),
        .push    (buf_push),
        .pop     (buf_pop),
        .wdata   (bus_word),
        .rdata   (buf_rdata),
        .ptr_o   (buf_ptr),
        .ovf_o   (buf_ovf)
    );

    hreg_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (st),
        .code      (code),
        .dir_wr    (dir_wr),
        .wdata     (bus_word),
        .write16   (write16),
        .stage_lo  (stage_lo),
        .write_hi  (write_hi),
        .snap      (snap),
        .buf_ovf   (buf_ovf),
        .buf_rdata (buf_rdata),
        .rd_word   (rd_word),
        .wide_a_o  (wide_a),
        .wide_b_o  (wide_b)
    );

    assign d_oe  = ~cs_n & ~rd_n & ~a0;
    assign d_out = d_oe ? rd_word : 16'h0000;

endmodule

// File: rtl/hreg_port_chk.sv
module hreg_port_chk
    import hreg_pkg::*;
#(
    parameter int BUF_DEPTH = 16,
    localparam int PTR_W    = $clog2(BUF_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input phase_e           st,
    input logic             cmd_evt,
    input logic             wr_evt,
    input logic             rd_evt,
    input logic [31:0]      wide_a,
    input logic [31:0]      wide_b,
    input logic             buf_ovf,
    input logic [PTR_W-1:0] buf_ptr,
    input logic [15:0]      d_out
);

    assert_wide_atomic_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(st == ST_WORD_HI && wr_evt) |=> ($stable(wide_a) && $stable(wide_b)));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_ovf |=> buf_ovf);

    assert_ptr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_ptr <= PTR_W'(BUF_DEPTH));

    assert_cmd_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_evt |=> (st == ST_WORD_LO || st == ST_STREAM));

    assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && !cmd_evt) |=> st == ST_DONE);

    assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_IDLE |-> d_out == 16'h0000);

    assert_single_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt || cmd_evt) |=> !(wr_evt || cmd_evt));

    assert_single_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt |=> !rd_evt);

endmodule

bind hreg_port hreg_port_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .cmd_evt (cmd_evt),
    .wr_evt  (wr_evt),
    .rd_evt  (rd_evt),
    .wide_a  (wide_a),
    .wide_b  (wide_b),
    .buf_ovf (buf_ovf),
    .buf_ptr (buf_ptr),
    .d_out   (d_out)
);

// File: tb/hreg_port_bench.sv
module hreg_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        a0 = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] d_in = 16'h0000;
    logic [15:0] d_out;
    logic        d_oe;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] obs;
    event        smp;

    always #2 clk = ~clk;

    hreg_port u_hreg_port (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .a0    (a0),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .d_in  (d_in),
        .d_out (d_out),
        .d_oe  (d_oe)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever the driver samples the bus
    initial begin
        forever begin
            @(smp);
            check(tag_q.pop_front(), obs, exp_q.pop_front());
        end
    end

    task automatic bus_write(input logic a0v, input logic [15:0] v,
                             input int hold = 4, input logic csv = 1'b0);
        @(negedge clk);
        cs_n = csv; a0 = a0v; d_in = v;
        @(negedge clk);
        wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic cmd(input logic [15:0] v);
        bus_write(1'b1, v);
    endtask

    task automatic wr(input logic [15:0] v);
        bus_write(1'b0, v);
    endtask

    task automatic rd(input logic [15:0] exp, input string tag);
        @(negedge clk);
        cs_n = 1'b0; a0 = 1'b0;
        @(negedge clk);
        rd_n = 1'b0;
        repeat (3) @(negedge clk);
        obs = d_out;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        ->smp;
        #0;
        rd_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset d_out", d_out, 16'h0000);
        check("R12 reset d_oe", {15'b0, d_oe}, 16'h0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R12: registers zero after reset
        cmd(16'h0001); rd(16'h0000, "R12 gp_a after reset");
        cmd(16'h0011); rd(16'h0000, "R12 wide_b lo after reset");
        rd(16'h0000, "R12 wide_b hi after reset");

        // R1, R2: junk upper command bits, one data phase
        cmd(16'hFF81); wr(16'h1234);
        cmd(16'h5A01);
        @(negedge clk); cs_n = 1'b0; a0 = 1'b0; @(negedge clk); rd_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 d_oe during data read", {15'b0, d_oe}, 16'h0001);
        rd_n = 1'b1; @(negedge clk); cs_n = 1'b1; repeat (5) @(negedge clk);
        cmd(16'h0001); rd(16'h1234, "R2 gp_a readback");
        rd(16'h0000, "R5 extra read of 16-bit reg");

        // R4, R6: lone lower word does not update
        cmd(16'h0090); wr(16'hBEEF);
        cmd(16'h0010); rd(16'h0000, "R4 wide_a lo after lone lower word");
        rd(16'h0000, "R4 wide_a hi after lone lower word");

        // R3, R5: full 32-bit write, extra write ignored
        cmd(16'h0090); wr(16'h5678); wr(16'h9ABC); wr(16'hFFFF);
        cmd(16'h0010); rd(16'h5678, "R3 wide_a lower word first");
        rd(16'h9ABC, "R3 wide_a upper word second");
        rd(16'h0000, "R5 third read of 32-bit reg");

        // R6: restart mid access
        cmd(16'h0091); wr(16'h1111);
        cmd(16'h0091); wr(16'h2222); wr(16'h3333);
        cmd(16'h0011); rd(16'h2222, "R6 wide_b lo after restart");
        rd(16'h3333, "R6 wide_b hi after restart");

        // R10: direction mismatches
        cmd(16'h0002); wr(16'h7777);
        cmd(16'h0002); rd(16'h0000, "R10 write under read command ignored");
        cmd(16'h0082); wr(16'h0BAD);
        cmd(16'h0082); rd(16'h0000, "R10 read under write command is zero");
        cmd(16'h0002); rd(16'h0BAD, "R10 gp_b written normally");

        // R9: unknown code
        cmd(16'h00C5); wr(16'hAAAA);
        cmd(16'h0045); rd(16'h0000, "R9 unknown code reads zero");
        cmd(16'h0001); rd(16'h1234, "R9 gp_a untouched by unknown write");

        // R11: long strobe, deselected strobe
        cmd(16'h0081); bus_write(1'b0, 16'h4321, 40);
        cmd(16'h0001); rd(16'h4321, "R11 long strobe one phase");
        cmd(16'h0081); bus_write(1'b0, 16'h1111, 4, 1'b1); wr(16'h2222);
        cmd(16'h0001); rd(16'h2222, "R11 strobe with cs high ignored");

        // R7: streaming and pointer restart
        cmd(16'h00B0);
        for (int i = 0; i < 5; i++) wr(16'(i * 3 + 1));
        cmd(16'h0030);
        for (int i = 0; i < 5; i++) rd(16'(i * 3 + 1), "R7 buffer stream word");
        cmd(16'h0030); rd(16'h0001, "R7 pointer restart");

        // R8: overflow
        cmd(16'h0020); rd(16'h0000, "R8 status clear before overflow");
        cmd(16'h00B0);
        for (int i = 0; i < 17; i++) wr(16'(i) ^ 16'h5A5A);
        cmd(16'h0020); rd(16'h0001, "R8 status after overflow");
        cmd(16'h0030);
        for (int i = 0; i < 16; i++) rd(16'(i) ^ 16'h5A5A, "R8 buffer words kept");
        rd(16'h0000, "R8 read past end is zero");
        cmd(16'h00A0); wr(16'h0000);
        cmd(16'h0020); rd(16'h0001, "R8 status sticky and read-only");

        repeat (4) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule